// File: doc/BRIEF.md
# ADC FIFO Interrupt Status Controller

This block holds the interrupt control word and the latched interrupt status of a FIFO-buffered ADC acquisition path. Software writes one control word that picks a single general interrupt source through a 2-bit select, gates that source with a general enable, and gates an acquisition-complete interrupt with its own enable. The same word carries three write-one-to-clear strobes. Each strobe acts only in the cycle of the write, so software never has to write it back to 0.

The acquisition logic feeds the block with event pulses and levels: channel scan done, FIFO half full, FIFO not empty, FIFO full, acquisition complete and burst complete, plus a burst-mode qualifier. Each status flag latches on a rising edge of its event and holds until software clears it. The block drives a single level interrupt request and presents a status word on a read port that always reflects the current state.

Top module: `acq_irq_ctrl`

## Requirements
- R1: After reset, every latched status bit, both enables and the select are 0. `irq_o` is 0 and `rd_data` is 0 apart from bit 4, which follows `fifo_nempty_i`.
- R2: Control word bits [1:0] select the general source. 0 selects no source, 1 selects `scan_done_i`, 2 selects `fifo_half_i` and 3 selects `fifo_nempty_i`. Only a rising edge of the selected source sets the general status, which is `rd_data` bit 1, on the clock edge where that source is first seen high.
- R3: Control bit 2 is the general enable. The general status latches whatever the enable is, but it drives `irq_o` only while the enable is 1.
- R4: Control bit 3 is the acquisition enable. A rising edge of `acq_done_i` sets the acquisition status (`rd_data` bit 0), which drives `irq_o` only while the acquisition enable is 1.
- R5: A write with bit 8 set clears the acquisition status, bit 9 clears the general status and bit 10 clears the FIFO-full flag. Each clear touches only its own flag. A write with a clear bit at 0 leaves that flag unchanged.
- R6: The clear bits act only in the cycle of the write. After a clear, the next event sets the flag again with no further write.
- R7: A rising edge of `fifo_full_i` sets the FIFO-full flag (`rd_data` bit 3). The flag stays set after `fifo_full_i` falls, until a clear.
- R8: A rising edge of `burst_done_i` sets the burst status (`rd_data` bit 2) only while `burst_mode_i` is 1. Bit 2 reads 0 whenever `burst_mode_i` is 0, and the latched burst status is dropped when burst mode is left.
- R9: When an event and the clear for its flag arrive in the same cycle, the flag ends up set.
- R10: `rd_data` bit 4 is the live `fifo_nempty_i` level. All bits above 4 read 0.
- R11: `irq_o` is a level that stays high until the enabled status that causes it is cleared or its enable is removed.
- R12: A source held high sets its flag once. After a clear during the high level, the flag stays 0 until the source falls and rises again. Changing the select to a source that is already high does not set the general status.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Control word write strobe |
| wr_data | input | DATA_W | Control word: select, enables, clear strobes |
| scan_done_i | input | 1 | End of channel scan event |
| fifo_half_i | input | 1 | FIFO half-full level |
| fifo_nempty_i | input | 1 | FIFO not-empty level |
| fifo_full_i | input | 1 | FIFO full level |
| acq_done_i | input | 1 | Requested sample count collected |
| burst_done_i | input | 1 | End of burst event |
| burst_mode_i | input | 1 | Burst mode active |
| rd_data | output | DATA_W | Status word |
| irq_o | output | 1 | Interrupt request level |

## Verification
The read word and the request are decoded combinationally from the status flags and enable registers. A flag that is wrongly set, wrongly cleared or stuck therefore shows on `rd_data` and `irq_o` in the same cycle it goes wrong, one clock after the stimulus that caused it. Directed scenarios drive each source through its select code, clear collisions, held levels and burst-mode exits, then sample the ports one edge later. Any drift between a flag and its event or strobe is caught before the next stimulus.

// File: rtl/acq_irq_pkg.sv
// Shared field positions and types for the ADC FIFO interrupt status block.
// Assumes the control word and status word are at least 11 bits wide.
package acq_irq_pkg;

    typedef enum logic [1:0] {
        SRC_NONE   = 2'd0,
        SRC_SCAN   = 2'd1,
        SRC_HALF   = 2'd2,
        SRC_NEMPTY = 2'd3
    } src_sel_e;

    // Control word bit positions
    localparam int unsigned CTL_SEL_LSB  = 0;
    localparam int unsigned CTL_GEN_EN   = 2;
    localparam int unsigned CTL_ACQ_EN   = 3;
    localparam int unsigned CTL_CLR_ACQ  = 8;
    localparam int unsigned CTL_CLR_GEN  = 9;
    localparam int unsigned CTL_CLR_FULL = 10;

    // Status word bit positions
    localparam int unsigned ST_ACQ    = 0;
    localparam int unsigned ST_GEN    = 1;
    localparam int unsigned ST_EOB    = 2;
    localparam int unsigned ST_FULL   = 3;
    localparam int unsigned ST_NEMPTY = 4;

    // Event vector indices
    localparam int unsigned EV_SCAN   = 0;
    localparam int unsigned EV_HALF   = 1;
    localparam int unsigned EV_NEMPTY = 2;
    localparam int unsigned EV_FULL   = 3;
    localparam int unsigned EV_ACQ    = 4;
    localparam int unsigned EV_EOB    = 5;
    localparam int unsigned NUM_EV    = 6;

    // Latched flag indices
    localparam int unsigned FL_ACQ  = 0;
    localparam int unsigned FL_GEN  = 1;
    localparam int unsigned FL_EOB  = 2;
    localparam int unsigned FL_FULL = 3;
    localparam int unsigned NUM_FL  = 4;

endpackage

// File: rtl/acq_irq_ctl_reg.sv
// Control register: stores the source select and both enables, and decodes
// the three self-clearing clear strobes from the write cycle.
// Assumes DATA_W covers the highest control bit position.
module acq_irq_ctl_reg
    import acq_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    output src_sel_e          sel_o,
    output logic              gen_en_o,
    output logic              acq_en_o,
    output logic              clr_acq_o,
    output logic              clr_gen_o,
    output logic              clr_full_o
);

    localparam logic [DATA_W-1:0] USED_MASK =
        (DATA_W'(3) << CTL_SEL_LSB) | (DATA_W'(1) << CTL_GEN_EN) |
        (DATA_W'(1) << CTL_ACQ_EN)  | (DATA_W'(1) << CTL_CLR_ACQ) |
        (DATA_W'(1) << CTL_CLR_GEN) | (DATA_W'(1) << CTL_CLR_FULL);

    src_sel_e sel_q;
    logic     gen_en_q;
    logic     acq_en_q;
    logic     unused_bits;

    // Store select and enables on every write; reset to all off.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q    <= SRC_NONE;
            gen_en_q <= 1'b0;
            acq_en_q <= 1'b0;
        end else if (wr_en) begin
            sel_q    <= src_sel_e'(wr_data[CTL_SEL_LSB +: 2]);
            gen_en_q <= wr_data[CTL_GEN_EN];
            acq_en_q <= wr_data[CTL_ACQ_EN];
        end
    end

    // Clear strobes live only in the write cycle, nothing is stored.
    always_comb begin
        clr_acq_o  = wr_en & wr_data[CTL_CLR_ACQ];
        clr_gen_o  = wr_en & wr_data[CTL_CLR_GEN];
        clr_full_o = wr_en & wr_data[CTL_CLR_FULL];
    end

    assign sel_o       = sel_q;
    assign gen_en_o    = gen_en_q;
    assign acq_en_o    = acq_en_q;
    assign unused_bits = ^(wr_data & ~USED_MASK);

endmodule

// File: rtl/acq_irq_edge.sv
// Per-line rising-edge detector. Each line keeps its own previous sample,
// so a pulse is reported in the cycle where the line is first seen high.
// Assumes inputs are synchronous to clk.
module acq_irq_edge #(
    parameter int unsigned WIDTH = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] lvl_i,
    output logic [WIDTH-1:0] rise_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_line
        logic prev_q;

        // Remember last cycle's level of this line.
        always_ff @(posedge clk) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= lvl_i[i];
        end

        assign rise_o[i] = lvl_i[i] & ~prev_q;
    end

endmodule

// File: rtl/acq_irq_src_pick.sv
// Routes the rising edge of the one general source named by the select.
// Code 0 routes nothing. Edges are detected before the mux, so a select
// change alone never produces an event.
module acq_irq_src_pick
    import acq_irq_pkg::*;
(
    input  src_sel_e sel_i,
    input  logic     scan_rise_i,
    input  logic     half_rise_i,
    input  logic     nempty_rise_i,
    output logic     hit_o
);

    // Pick the edge of the selected source.
    always_comb begin
        unique case (sel_i)
            SRC_SCAN:   hit_o = scan_rise_i;
            SRC_HALF:   hit_o = half_rise_i;
            SRC_NEMPTY: hit_o = nempty_rise_i;
            default:    hit_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/acq_irq_flag.sv
// Bank of sticky status flags. A set in the same cycle as a clear wins,
// so no event is lost to a racing software clear.
module acq_irq_flag #(
    parameter int unsigned WIDTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] set_i,
    input  logic [WIDTH-1:0] clr_i,
    output logic [WIDTH-1:0] flag_o
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_flag
        logic q;

        // Hold the flag; set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)        q <= 1'b0;
            else if (set_i[i]) q <= 1'b1;
            else if (clr_i[i]) q <= 1'b0;
        end

        assign flag_o[i] = q;
    end

endmodule

// File: rtl/acq_irq_ctrl.sv
// Top of the ADC FIFO interrupt status block: control register, edge
// detection, general source selection, sticky flags, status read word and
// interrupt request. Event inputs are assumed synchronous to clk.
module acq_irq_ctrl
    import acq_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              scan_done_i,
    input  logic              fifo_half_i,
    input  logic              fifo_nempty_i,
    input  logic              fifo_full_i,
    input  logic              acq_done_i,
    input  logic              burst_done_i,
    input  logic              burst_mode_i,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq_o
);

    src_sel_e          sel;
    logic              gen_en;
    logic              acq_en;
    logic              clr_acq;
    logic              clr_gen;
    logic              clr_full;
    logic [NUM_EV-1:0] ev_lvl;
    logic [NUM_EV-1:0] ev_rise;
    logic              gen_hit;
    logic [NUM_FL-1:0] fl_set;
    logic [NUM_FL-1:0] fl_clr;
    logic [NUM_FL-1:0] flag;

    acq_irq_ctl_reg #(.DATA_W(DATA_W)) u_ctl (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .sel_o      (sel),
        .gen_en_o   (gen_en),
        .acq_en_o   (acq_en),
        .clr_acq_o  (clr_acq),
        .clr_gen_o  (clr_gen),
        .clr_full_o (clr_full)
    );

    // Gather event inputs into one vector for edge detection.
    always_comb begin
        ev_lvl            = '0;
        ev_lvl[EV_SCAN]   = scan_done_i;
        ev_lvl[EV_HALF]   = fifo_half_i;
        ev_lvl[EV_NEMPTY] = fifo_nempty_i;
        ev_lvl[EV_FULL]   = fifo_full_i;
        ev_lvl[EV_ACQ]    = acq_done_i;
        ev_lvl[EV_EOB]    = burst_done_i;
    end

    acq_irq_edge #(.WIDTH(NUM_EV)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .lvl_i  (ev_lvl),
        .rise_o (ev_rise)
    );

    acq_irq_src_pick u_pick (
        .sel_i         (sel),
        .scan_rise_i   (ev_rise[EV_SCAN]),
        .half_rise_i   (ev_rise[EV_HALF]),
        .nempty_rise_i (ev_rise[EV_NEMPTY]),
        .hit_o         (gen_hit)
    );

    // Map events and strobes onto flag set and clear lines.
    always_comb begin
        fl_set          = '0;
        fl_clr          = '0;
        fl_set[FL_ACQ]  = ev_rise[EV_ACQ];
        fl_set[FL_GEN]  = gen_hit;
        fl_set[FL_EOB]  = ev_rise[EV_EOB] & burst_mode_i;
        fl_set[FL_FULL] = ev_rise[EV_FULL];
        fl_clr[FL_ACQ]  = clr_acq;
        fl_clr[FL_GEN]  = clr_gen;
        fl_clr[FL_EOB]  = ~burst_mode_i;
        fl_clr[FL_FULL] = clr_full;
    end

    acq_irq_flag #(.WIDTH(NUM_FL)) u_flag (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (fl_set),
        .clr_i  (fl_clr),
        .flag_o (flag)
    );

    // Build the status word; burst status is masked outside burst mode.
    always_comb begin
        rd_data            = '0;
        rd_data[ST_ACQ]    = flag[FL_ACQ];
        rd_data[ST_GEN]    = flag[FL_GEN];
        rd_data[ST_EOB]    = flag[FL_EOB] & burst_mode_i;
        rd_data[ST_FULL]   = flag[FL_FULL];
        rd_data[ST_NEMPTY] = fifo_nempty_i;
    end

    // Request level from enabled sticky statuses.
    assign irq_o = (flag[FL_GEN] & gen_en) | (flag[FL_ACQ] & acq_en);

endmodule

// File: rtl/acq_irq_ctrl_chk.sv
// Property checker for acq_irq_ctrl, attached by bind. Observes ports only.
module acq_irq_ctrl_chk
    import acq_irq_pkg::*;
#(
    parameter int unsigned DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [DATA_W-1:0] wr_data,
    input logic              fifo_full_i,
    input logic              acq_done_i,
    input logic              burst_mode_i,
    input logic [DATA_W-1:0] rd_data,
    input logic              irq_o
);

    // R11: a request needs a latched acquisition or general status
    assert_irq_has_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (rd_data[ST_ACQ] | rd_data[ST_GEN]));

    // R5: general status only falls after its clear strobe
    assert_gen_fall_by_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[ST_GEN]) |-> $past(wr_en && wr_data[CTL_CLR_GEN]));

    // R5: acquisition status only falls after its clear strobe
    assert_acq_fall_by_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[ST_ACQ]) |-> $past(wr_en && wr_data[CTL_CLR_ACQ]));

    // R7: full flag survives the FIFO draining
    assert_full_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rd_data[ST_FULL]) |-> $past(wr_en && wr_data[CTL_CLR_FULL]));

    // R7: full flag only rises after the full input was high
    assert_full_rise_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_data[ST_FULL]) |-> $past(fifo_full_i));

    // R8: burst status reads 0 outside burst mode
    assert_eob_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !burst_mode_i |-> !rd_data[ST_EOB]);

    // R9: acquisition event always lands, even against a clear
    assert_acq_set_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acq_done_i) |=> rd_data[ST_ACQ]);

endmodule

bind acq_irq_ctrl acq_irq_ctrl_chk #(.DATA_W(DATA_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_data      (wr_data),
    .fifo_full_i  (fifo_full_i),
    .acq_done_i   (acq_done_i),
    .burst_mode_i (burst_mode_i),
    .rd_data      (rd_data),
    .irq_o        (irq_o)
);

// File: tb/sim_acq_irq_ctrl.sv
// Directed bench for acq_irq_ctrl: one task per scenario, each self-checking.
module sim_acq_irq_ctrl;

    localparam int unsigned DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          scan_done = 1'b0;
    logic          fifo_half = 1'b0;
    logic          fifo_nempty = 1'b0;
    logic          fifo_full = 1'b0;
    logic          acq_done = 1'b0;
    logic          burst_done = 1'b0;
    logic          burst_mode = 1'b0;
    logic [DW-1:0] rd_data;
    logic          irq;

    int n_chk = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    acq_irq_ctrl #(.DATA_W(DW)) u0 (
        .clk           (clk),
        .rst_n         (rst_n),
        .wr_en         (wr_en),
        .wr_data       (wr_data),
        .scan_done_i   (scan_done),
        .fifo_half_i   (fifo_half),
        .fifo_nempty_i (fifo_nempty),
        .fifo_full_i   (fifo_full),
        .acq_done_i    (acq_done),
        .burst_done_i  (burst_done),
        .burst_mode_i  (burst_mode),
        .rd_data       (rd_data),
        .irq_o         (irq)
    );

    function automatic logic [DW-1:0] ctl(input logic [1:0] sel, input logic gen,
                                          input logic acq, input logic ca,
                                          input logic cg, input logic cf);
        return {5'b0, cf, cg, ca, 4'b0, acq, gen, sel};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
        scan_done = 0; fifo_half = 0; fifo_nempty = 0; fifo_full = 0;
        acq_done = 0; burst_done = 0; burst_mode = 0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [DW-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 rd_data", rd_data, 0);
        chk("R1 irq", irq, 0);
        fifo_nempty = 1;
        @(negedge clk);
        chk("R1 nempty live", rd_data, 16'h0010);
        chk("R1 no set with select 0", rd_data[1], 0);
    endtask

    task automatic t_scan_select();
        do_reset();
        wr(ctl(2'd1, 1, 0, 0, 0, 0));
        fifo_half = 1;
        @(negedge clk);
        fifo_half = 0;
        chk("R2 unselected half ignored", rd_data, 0);
        scan_done = 1;
        @(negedge clk);
        scan_done = 0;
        chk("R2 scan sets general", rd_data, 16'h0002);
        chk("R3 irq with enable", irq, 1);
        idle(3);
        chk("R11 irq held", irq, 1);
        wr(ctl(2'd1, 1, 0, 0, 1, 0));
        chk("R5 general cleared", rd_data, 0);
        chk("R11 irq drops after clear", irq, 0);
        scan_done = 1;
        @(negedge clk);
        scan_done = 0;
        chk("R6 sets again without rewrite", rd_data[1], 1);
    endtask

    task automatic t_half_level();
        do_reset();
        wr(ctl(2'd2, 1, 0, 0, 0, 0));
        fifo_half = 1;
        @(negedge clk);
        chk("R2 half sets general", rd_data[1], 1);
        wr(ctl(2'd2, 1, 0, 0, 1, 0));
        chk("R12 cleared while held", rd_data[1], 0);
        idle(3);
        chk("R12 no re-set while level high", rd_data[1], 0);
        fifo_half = 0;
        @(negedge clk);
        fifo_half = 1;
        @(negedge clk);
        chk("R12 new rising edge sets", rd_data[1], 1);
    endtask

    task automatic t_nempty_select();
        do_reset();
        wr(ctl(2'd2, 1, 0, 0, 0, 0));
        fifo_nempty = 1;
        @(negedge clk);
        chk("R12 nempty unselected", rd_data, 16'h0010);
        wr(ctl(2'd3, 1, 0, 0, 0, 0));
        chk("R12 select change no set", rd_data, 16'h0010);
        fifo_nempty = 0;
        @(negedge clk);
        fifo_nempty = 1;
        @(negedge clk);
        chk("R2 nempty sets general", rd_data, 16'h0012);
        chk("R10 upper bits zero", rd_data[15:5], 0);
    endtask

    task automatic t_gen_enable();
        do_reset();
        wr(ctl(2'd1, 0, 0, 0, 0, 0));
        scan_done = 1;
        @(negedge clk);
        scan_done = 0;
        chk("R3 status latches without enable", rd_data[1], 1);
        chk("R3 no irq without enable", irq, 0);
        wr(ctl(2'd1, 1, 0, 0, 0, 0));
        chk("R3 irq after enable", irq, 1);
        wr(ctl(2'd1, 0, 0, 0, 0, 0));
        chk("R11 irq drops with enable off", irq, 0);
    endtask

    task automatic t_acq();
        do_reset();
        wr(ctl(2'd1, 0, 0, 0, 0, 0));
        scan_done = 1;
        @(negedge clk);
        scan_done = 0;
        acq_done = 1;
        @(negedge clk);
        acq_done = 0;
        chk("R4 acq status", rd_data, 16'h0003);
        chk("R4 no irq acq disabled", irq, 0);
        wr(ctl(2'd1, 0, 1, 0, 0, 0));
        chk("R4 irq acq enabled", irq, 1);
        wr(ctl(2'd1, 0, 1, 0, 0, 0));
        chk("R5 zero clear bits no effect", rd_data, 16'h0003);
        wr(ctl(2'd1, 0, 1, 1, 0, 0));
        chk("R5 acq clear only acq", rd_data, 16'h0002);
        chk("R4 irq off after acq clear", irq, 0);
    endtask

    task automatic t_full();
        do_reset();
        fifo_full = 1;
        @(negedge clk);
        chk("R7 full latched", rd_data[3], 1);
        fifo_full = 0;
        idle(2);
        chk("R7 full held after drain", rd_data[3], 1);
        wr(ctl(2'd0, 0, 0, 1, 1, 0));
        chk("R5 other clears leave full", rd_data[3], 1);
        wr(ctl(2'd0, 0, 0, 0, 0, 1));
        chk("R5 full cleared", rd_data[3], 0);
    endtask

    task automatic t_collision();
        do_reset();
        @(negedge clk);
        acq_done = 1;
        wr_en = 1; wr_data = ctl(2'd0, 0, 1, 1, 0, 0);
        @(negedge clk);
        acq_done = 0; wr_en = 0; wr_data = '0;
        chk("R9 set beats clear", rd_data[0], 1);
        @(negedge clk);
        fifo_full = 1;
        wr_en = 1; wr_data = ctl(2'd0, 0, 1, 0, 0, 1);
        @(negedge clk);
        fifo_full = 0; wr_en = 0; wr_data = '0;
        chk("R9 full set beats clear", rd_data[3], 1);
    endtask

    task automatic t_burst();
        do_reset();
        burst_done = 1;
        @(negedge clk);
        burst_done = 0;
        burst_mode = 1;
        @(negedge clk);
        chk("R8 no latch outside burst mode", rd_data[2], 0);
        burst_done = 1;
        @(negedge clk);
        burst_done = 0;
        chk("R8 burst status set", rd_data[2], 1);
        burst_mode = 0;
        @(negedge clk);
        chk("R8 masked out of burst mode", rd_data[2], 0);
        burst_mode = 1;
        @(negedge clk);
        chk("R8 dropped on mode exit", rd_data[2], 0);
        chk("R8 no irq from burst", irq, 0);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_scan_select();
        t_half_level();
        t_nempty_select();
        t_gen_enable();
        t_acq();
        t_full();
        t_collision();
        t_burst();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule